// File: doc/BRIEF.md
# SPI Controller Configuration Register File

This block is the firmware-visible register file of an SPI controller. A 64-bit register bus moves one whole 8-byte word per access. Byte 0 of the word occupies bits [63:56], and the register index is the byte address shifted right by three. The block holds nine registers:

- error
- counter configuration
- configuration 1
- clock configuration
- memory map
- transmit data
- receive data
- sequence opcodes
- status

Accesses to the data registers update the status flags as a side effect.

The sequencer that normally drives the controller is represented by two strobes. A receive-load strobe delivers one received word. A transmit-consume strobe takes the pending transmit word. The clock-configuration register carries a two-step software reset key. Writing 0x5 into its low nibble, then writing 0xA into that nibble, returns the register to its hard-reset value.

Top module: `spi_cfg_regfile`

## Requirements
- R1: After reset, every register reads zero except clock configuration. Clock configuration reads the parameter CLK_RST_VAL, and rd_vld and busy_err are low.
- R2: A read issued in cycle N returns rd_vld=1 with rd_data in cycle N+1. The index is bus_addr>>3, and bus_addr[2:0] is ignored. Indices are: 0 error, 1 counter config, 2 config 1, 3 clock config, 4 memory map, 5 transmit data, 6 receive data, 7 opcodes, 8 status.
- R3: A read of an index above 8 returns all ones with rd_err=1. A write to such an index changes no register.
- R4: The error, counter-config, config-1, memory-map and receive-data registers read back the last value written.
- R5: Status bit 63 is receive-full and bit 62 is receive-overrun.
  - A receive-load stores rx_data and sets bit 63.
  - A receive-load while bit 63 is set keeps the old data and sets bit 62.
  - A bus read of receive data clears bit 63.
- R6: Status bit 61 is transmit-full and bit 60 is transmit-underrun. An accepted transmit-data write stores the word on tx_data, sets bit 61 and clears bit 60.
- R7: A transmit-data write while bit 61 is set leaves the register unchanged and pulses busy_err one cycle later.
- R8: A transmit-consume clears bit 61 when it is set. When bit 61 is clear, a transmit-consume sets bit 60.
- R9: The reset-control field of clock configuration is bits [3:0]. A write carrying 0xA there, while the field holds 0x5, loads CLK_RST_VAL. Every other write stores the data.
- R10: Opcode k of the opcode register sits in bits [63-8k -: 8], in seq_ops and in read-back alike.
- R11: A status write sets bit 62 from wdata[62] and bit 59 (transmit-overrun) from wdata[59]. All other status bits ignore it, and bits [58:0] read zero.
- R12: A receive-data read in the same cycle as a receive-load returns the old word. The new word is accepted, bit 63 stays set and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write word |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 64 | Read word |
| rd_err | output | 1 | Read hit an unmapped index |
| busy_err | output | 1 | Transmit write refused while full |
| rx_load | input | 1 | Sequencer delivers a received word |
| rx_data | input | 64 | Received word |
| tx_take | input | 1 | Sequencer consumes the transmit word |
| tx_data | output | 64 | Transmit-data register |
| seq_ops | output | 64 | Opcode register, opcode 0 in the top byte |
| clk_cfg | output | 64 | Clock-configuration register |

## Verification
The assertions assume that bus_vld, bus_wr and the strobes are clean single-cycle levels sampled at the rising edge. They also assume that a bus write to the receive-data register never coincides with a receive-load, because the load takes priority and the bus data is then dropped. Stimulus is applied on the falling edge, one access at a time. The only deliberate collision is the read-versus-load case of R12. Transmit-consume is issued only after the status word has been read back, so each flag transition is observed on its own.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned NUM_REGS = 9;

  typedef enum logic [3:0] {
    IDX_ERR  = 4'd0,
    IDX_CTR  = 4'd1,
    IDX_CFG1 = 4'd2,
    IDX_CLK  = 4'd3,
    IDX_MMAP = 4'd4,
    IDX_TXD  = 4'd5,
    IDX_RXD  = 4'd6,
    IDX_SEQ  = 4'd7,
    IDX_STAT = 4'd8
  } reg_idx_e;

  localparam int unsigned ST_RX_FULL = 63;
  localparam int unsigned ST_RX_OVR  = 62;
  localparam int unsigned ST_TX_FULL = 61;
  localparam int unsigned ST_TX_UND  = 60;
  localparam int unsigned ST_TX_OVR  = 59;

  typedef struct packed {
    logic rx_full;
    logic rx_ovr;
    logic tx_full;
    logic tx_und;
    logic tx_ovr;
  } stat_t;
endpackage

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode #(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = ADDR_W - 3
) (
  input  logic                                bus_vld,
  input  logic                                bus_wr,
  input  logic [ADDR_W-1:0]                   bus_addr,
  output logic [IDX_W-1:0]                    idx,
  output logic [spi_cfg_pkg::NUM_REGS-1:0]    wr_sel,
  output logic [spi_cfg_pkg::NUM_REGS-1:0]    rd_sel,
  output logic                                rd_miss
);
  logic [2:0] unused_byte_lane;

  assign unused_byte_lane = bus_addr[2:0];
  assign idx              = bus_addr[ADDR_W-1:3];

  for (genvar i = 0; i < int'(spi_cfg_pkg::NUM_REGS); i++) begin : g_sel
    assign wr_sel[i] = bus_vld &  bus_wr & (idx == IDX_W'(i));
    assign rd_sel[i] = bus_vld & ~bus_wr & (idx == IDX_W'(i));
  end

  assign rd_miss = bus_vld & ~bus_wr & ~(|rd_sel);
endmodule

// File: rtl/spi_cfg_status.sv
module spi_cfg_status
  import spi_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_rxd,
  input  logic  wr_txd,
  input  logic  wr_stat,
  input  logic  wd_rx_ovr,
  input  logic  wd_tx_ovr,
  input  logic  rx_load,
  input  logic  tx_take,
  output stat_t stat_q,
  output logic  rx_accept,
  output logic  tx_accept,
  output logic  tx_busy
);
  stat_t stat_d;
  logic  stat_en;

  assign rx_accept = rx_load & (~stat_q.rx_full | rd_rxd);
  assign tx_accept = wr_txd & ~stat_q.tx_full;
  assign tx_busy   = wr_txd &  stat_q.tx_full;
  assign stat_en   = rd_rxd | wr_txd | wr_stat | rx_load | tx_take;

  always_comb begin
    stat_d = stat_q;
    if (rx_accept)   stat_d.rx_full = 1'b1;
    else if (rd_rxd) stat_d.rx_full = 1'b0;

    stat_d.rx_ovr = (wr_stat ? wd_rx_ovr : stat_q.rx_ovr) | (rx_load & ~rx_accept);

    if (tx_accept)    stat_d.tx_full = 1'b1;
    else if (tx_take) stat_d.tx_full = 1'b0;

    if (tx_accept)                          stat_d.tx_und = 1'b0;
    else if (tx_take && !stat_q.tx_full)    stat_d.tx_und = 1'b1;

    if (wr_stat) stat_d.tx_ovr = wd_tx_ovr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  AST_RX_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && stat_q.rx_full && !rd_rxd) |=> stat_q.rx_ovr); // R5
  AST_TX_UND_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !stat_q.tx_full && !wr_txd) |=> (stat_q.tx_und && !stat_q.tx_full)); // R8
  AST_RX_READ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && rd_rxd) |=> (stat_q.rx_full && $stable(stat_q.rx_ovr))); // R12
endmodule

// File: rtl/spi_cfg_clkkey.sv
module spi_cfg_clkkey #(
  parameter int unsigned         DATA_W  = 64,
  parameter int unsigned         KEY_W   = 4,
  parameter logic [DATA_W-1:0]   RST_VAL = '0,
  parameter logic [KEY_W-1:0]    KEY_ARM = 4'h5,
  parameter logic [KEY_W-1:0]    KEY_HIT = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic              key_match;
  logic [DATA_W-1:0] d;

  assign key_match = (q[KEY_W-1:0] == KEY_ARM) && (wdata[KEY_W-1:0] == KEY_HIT);
  assign d         = key_match ? RST_VAL : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= d;
  end

  AST_KEY_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && q[KEY_W-1:0] == KEY_ARM && wdata[KEY_W-1:0] == KEY_HIT) |=> (q == RST_VAL)); // R9
endmodule

// File: rtl/spi_cfg_seqop.sv
module spi_cfg_seqop #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned NUM_OPS = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ops
);
  logic [7:0] op_q [NUM_OPS];

  for (genvar k = 0; k < int'(NUM_OPS); k++) begin : g_op
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     op_q[k] <= '0;
      else if (wr_en) op_q[k] <= wdata[DATA_W-1-8*k -: 8];
    end
    assign ops[DATA_W-1-8*k -: 8] = op_q[k];
  end
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [63:0]       CLK_RST_VAL = 64'h0000_00F0_0000_0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic              rd_vld,
  output logic [63:0]       rd_data,
  output logic              rd_err,
  output logic              busy_err,
  input  logic              rx_load,
  input  logic [63:0]       rx_data,
  input  logic              tx_take,
  output logic [63:0]       tx_data,
  output logic [63:0]       seq_ops,
  output logic [63:0]       clk_cfg
);
  localparam int unsigned IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] wr_sel;
  logic [NUM_REGS-1:0] rd_sel;
  logic                rd_miss;
  logic                rd_req;

  stat_t       stat_q;
  logic        rx_accept, tx_accept, tx_busy;
  logic [63:0] stat_word;

  logic [63:0] err_q, ctr_q, cfg1_q, mmap_q, txd_q, rxd_q;
  logic [63:0] rxd_d;
  logic        rxd_en;
  logic [63:0] rd_mux;

  assign rd_req = bus_vld & ~bus_wr;

  spi_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_vld (bus_vld),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .idx     (idx),
    .wr_sel  (wr_sel),
    .rd_sel  (rd_sel),
    .rd_miss (rd_miss)
  );

  spi_cfg_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_rxd   (rd_sel[IDX_RXD]),
    .wr_txd   (wr_sel[IDX_TXD]),
    .wr_stat  (wr_sel[IDX_STAT]),
    .wd_rx_ovr(bus_wdata[ST_RX_OVR]),
    .wd_tx_ovr(bus_wdata[ST_TX_OVR]),
    .rx_load  (rx_load),
    .tx_take  (tx_take),
    .stat_q   (stat_q),
    .rx_accept(rx_accept),
    .tx_accept(tx_accept),
    .tx_busy  (tx_busy)
  );

  spi_cfg_clkkey #(.DATA_W(DATA_W), .RST_VAL(CLK_RST_VAL)) u_clkkey (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_sel[IDX_CLK]),
    .wdata(bus_wdata),
    .q    (clk_cfg)
  );

  spi_cfg_seqop #(.DATA_W(DATA_W)) u_seqop (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_sel[IDX_SEQ]),
    .wdata(bus_wdata),
    .ops  (seq_ops)
  );

  // plain read/write registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      ctr_q  <= '0;
      cfg1_q <= '0;
      mmap_q <= '0;
    end else begin
      if (wr_sel[IDX_ERR])  err_q  <= bus_wdata;
      if (wr_sel[IDX_CTR])  ctr_q  <= bus_wdata;
      if (wr_sel[IDX_CFG1]) cfg1_q <= bus_wdata;
      if (wr_sel[IDX_MMAP]) mmap_q <= bus_wdata;
    end
  end

  // transmit hold register: refused while full
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         txd_q <= '0;
    else if (tx_accept) txd_q <= bus_wdata;
  end

  // receive hold register: sequencer load wins over a bus write
  assign rxd_en = rx_accept | wr_sel[IDX_RXD];
  assign rxd_d  = rx_accept ? rx_data : bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rxd_q <= '0;
    else if (rxd_en) rxd_q <= rxd_d;
  end

  always_comb begin
    stat_word             = '0;
    stat_word[ST_RX_FULL] = stat_q.rx_full;
    stat_word[ST_RX_OVR]  = stat_q.rx_ovr;
    stat_word[ST_TX_FULL] = stat_q.tx_full;
    stat_word[ST_TX_UND]  = stat_q.tx_und;
    stat_word[ST_TX_OVR]  = stat_q.tx_ovr;
  end

  always_comb begin
    case (idx)
      IDX_W'(IDX_ERR):  rd_mux = err_q;
      IDX_W'(IDX_CTR):  rd_mux = ctr_q;
      IDX_W'(IDX_CFG1): rd_mux = cfg1_q;
      IDX_W'(IDX_CLK):  rd_mux = clk_cfg;
      IDX_W'(IDX_MMAP): rd_mux = mmap_q;
      IDX_W'(IDX_TXD):  rd_mux = txd_q;
      IDX_W'(IDX_RXD):  rd_mux = rxd_q;
      IDX_W'(IDX_SEQ):  rd_mux = seq_ops;
      IDX_W'(IDX_STAT): rd_mux = stat_word;
      default:          rd_mux = '1;
    endcase
  end

  // response stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld   <= 1'b0;
      rd_err   <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      rd_vld   <= rd_req;
      rd_err   <= rd_miss;
      busy_err <= tx_busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_req) rd_data <= rd_mux;
  end

  assign tx_data = txd_q;

  AST_RD_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_vld); // R2
  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_vld && rd_data == '1)); // R3
  AST_TX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[IDX_TXD] && tx_busy) |=> ($stable(tx_data) && busy_err)); // R7
  AST_TX_ACCEPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> (stat_q.tx_full && !stat_q.tx_und)); // R6
endmodule

// File: tb/spi_cfg_regfile_tb.sv
module spi_cfg_regfile_tb;
  localparam logic [63:0] TB_CLK_RST = 64'h0000_00F0_0000_0800;
  localparam logic [63:0] ONES       = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        rd_vld, rd_err, busy_err;
  logic [63:0] rd_data;
  logic        rx_load = 1'b0;
  logic [63:0] rx_data = '0;
  logic        tx_take = 1'b0;
  logic [63:0] tx_data, seq_ops, clk_cfg;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  spi_cfg_regfile #(.ADDR_W(8), .CLK_RST_VAL(TB_CLK_RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_vld(rd_vld),
    .rd_data(rd_data), .rd_err(rd_err), .busy_err(busy_err),
    .rx_load(rx_load), .rx_data(rx_data), .tx_take(tx_take),
    .tx_data(tx_data), .seq_ops(seq_ops), .clk_cfg(clk_cfg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [63:0] d, output logic busy);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0; bus_wr = 1'b0;
    busy = busy_err;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [63:0] d, output logic err);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_vld = 1'b0;
    if (rd_vld !== 1'b1) begin
      checks++; failures++;
      $display("FAIL R2 rd_vld act=%b exp=1", rd_vld);
    end
    d = rd_data; err = rd_err;
  endtask

  task automatic pulse_rx(input logic [63:0] d);
    @(negedge clk); rx_load = 1'b1; rx_data = d;
    @(negedge clk); rx_load = 1'b0;
  endtask

  task automatic pulse_take();
    @(negedge clk); tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
  endtask

  function automatic logic [63:0] st(input logic rf, ro, tf, tu, to);
    logic [63:0] w = '0;
    w[63] = rf; w[62] = ro; w[61] = tf; w[60] = tu; w[59] = to;
    return w;
  endfunction

  task automatic t_reset();
    logic [63:0] d; logic e;
    chk("R1 rd_vld", {63'd0, rd_vld}, 64'd0);
    chk("R1 busy_err", {63'd0, busy_err}, 64'd0);
    for (int i = 0; i < 9; i++) begin
      bus_read(8'(i * 8), d, e);
      chk($sformatf("R1 reg%0d", i), d, (i == 3) ? TB_CLK_RST : 64'd0);
    end
    chk("R1 clk_cfg port", clk_cfg, TB_CLK_RST);
  endtask

  task automatic t_plain();
    logic [63:0] d; logic e, b;
    bus_write(8'h00, 64'h1111_2222_3333_4444, b);
    bus_write(8'h08, 64'hA5A5_0000_FFFF_0001, b);
    bus_write(8'h10, 64'h0123_4567_89AB_CDEF, b);
    bus_write(8'h20, 64'hDEAD_BEEF_0000_0042, b);
    bus_write(8'h30, 64'h7777_8888_9999_AAAA, b);
    bus_read(8'h00, d, e); chk("R4 err", d, 64'h1111_2222_3333_4444);
    bus_read(8'h0D, d, e); chk("R2 low bits ignored ctr", d, 64'hA5A5_0000_FFFF_0001);
    bus_read(8'h10, d, e); chk("R4 cfg1", d, 64'h0123_4567_89AB_CDEF);
    bus_read(8'h20, d, e); chk("R4 mmap", d, 64'hDEAD_BEEF_0000_0042);
    bus_read(8'h30, d, e); chk("R4 rxd", d, 64'h7777_8888_9999_AAAA);
    chk("R2 mapped no err", {63'd0, e}, 64'd0);
  endtask

  task automatic t_unmapped();
    logic [63:0] d; logic e, b;
    bus_read(8'h48, d, e);
    chk("R3 unmapped data", d, ONES);
    chk("R3 unmapped err", {63'd0, e}, 64'd1);
    bus_write(8'hF8, 64'h0, b);
    bus_write(8'h50, 64'h0, b);
    bus_read(8'h00, d, e); chk("R3 write ignored err", d, 64'h1111_2222_3333_4444);
    bus_read(8'h40, d, e); chk("R3 write ignored status", d, 64'd0);
  endtask

  task automatic t_rx();
    logic [63:0] d; logic e;
    pulse_rx(64'hCAFE_0000_0000_0001);
    bus_read(8'h40, d, e); chk("R5 full set", d, st(1, 0, 0, 0, 0));
    pulse_rx(64'hCAFE_0000_0000_0002);
    bus_read(8'h40, d, e); chk("R5 overrun set", d, st(1, 1, 0, 0, 0));
    bus_read(8'h30, d, e); chk("R5 old data kept", d, 64'hCAFE_0000_0000_0001);
    bus_read(8'h40, d, e); chk("R5 read clears full", d, st(0, 1, 0, 0, 0));
  endtask

  task automatic t_status_write();
    logic [63:0] d; logic e, b;
    bus_write(8'h28, 64'h55, b);
    bus_write(8'h40, ONES, b);
    bus_read(8'h40, d, e); chk("R11 ones written", d, st(0, 1, 1, 0, 1));
    bus_write(8'h40, 64'd0, b);
    bus_read(8'h40, d, e); chk("R11 zeros written", d, st(0, 0, 1, 0, 0));
    pulse_take();
  endtask

  task automatic t_rx_collide();
    logic [63:0] d; logic e;
    pulse_rx(64'h0000_0000_0000_0D03);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = 8'h30;
    rx_load = 1'b1; rx_data = 64'h0000_0000_0000_0D04;
    @(negedge clk);
    bus_vld = 1'b0; rx_load = 1'b0;
    chk("R12 old word returned", rd_data, 64'h0000_0000_0000_0D03);
    bus_read(8'h40, d, e); chk("R12 full no overrun", d, st(1, 0, 0, 0, 0));
    bus_read(8'h30, d, e); chk("R12 new word held", d, 64'h0000_0000_0000_0D04);
  endtask

  task automatic t_tx();
    logic [63:0] d; logic e, b;
    bus_write(8'h28, 64'h1234_0000_0000_00A1, b);
    chk("R6 tx_data", tx_data, 64'h1234_0000_0000_00A1);
    chk("R6 no busy", {63'd0, b}, 64'd0);
    bus_read(8'h40, d, e); chk("R6 full set", d, st(0, 0, 1, 0, 0));
    bus_write(8'h28, 64'h9999_0000_0000_00B2, b);
    chk("R7 busy pulse", {63'd0, b}, 64'd1);
    chk("R7 tx kept", tx_data, 64'h1234_0000_0000_00A1);
    bus_read(8'h28, d, e); chk("R7 readback kept", d, 64'h1234_0000_0000_00A1);
    chk("R7 busy cleared", {63'd0, busy_err}, 64'd0);
    pulse_take();
    bus_read(8'h40, d, e); chk("R8 take clears full", d, st(0, 0, 0, 0, 0));
    pulse_take();
    bus_read(8'h40, d, e); chk("R8 underrun", d, st(0, 0, 0, 1, 0));
    bus_write(8'h28, 64'h0000_0000_0000_00C3, b);
    bus_read(8'h40, d, e); chk("R6 underrun cleared", d, st(0, 0, 1, 0, 0));
    pulse_take();
  endtask

  task automatic t_clk();
    logic [63:0] d; logic e, b;
    bus_write(8'h18, 64'h0000_1111_0000_0005, b);
    bus_write(8'h18, 64'hFFFF_0000_0000_333A, b);
    bus_read(8'h18, d, e); chk("R9 key restores", d, TB_CLK_RST);
    bus_write(8'h18, 64'h0000_0000_0000_0003, b);
    bus_write(8'h18, 64'h0000_0000_0000_002A, b);
    bus_read(8'h18, d, e); chk("R9 wrong arm stores", d, 64'h0000_0000_0000_002A);
    bus_write(8'h18, 64'h0000_0000_0000_0005, b);
    bus_write(8'h18, 64'h0000_0000_0000_0007, b);
    chk("R9 wrong fire stores", clk_cfg, 64'h0000_0000_0000_0007);
  endtask

  task automatic t_seq();
    logic [63:0] d; logic e, b;
    bus_write(8'h38, 64'h0102_0304_0506_0708, b);
    chk("R10 opcode0 top byte", {56'd0, seq_ops[63:56]}, 64'h01);
    chk("R10 opcode7 low byte", {56'd0, seq_ops[7:0]}, 64'h08);
    bus_read(8'h38, d, e); chk("R10 readback order", d, 64'h0102_0304_0506_0708);
  endtask

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_unmapped();
    t_rx();
    t_status_write();
    t_rx_collide();
    t_tx();
    t_clk();
    t_seq();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule